// File: doc/BRIEF.md
# Read-Address Sequence Command Detector

This block watches the read and write cycles of a memory bus and treats one particular run of read addresses as a command. Reads carry no command meaning one at a time. Only five fixed addresses, read back to back in one order and followed by a sixth address, are recognised. The sixth address picks one of four commands: save the RAM to its nonvolatile copy, restore the RAM from that copy, turn automatic save-on-power-loss off, or turn it on again.

The bus logic supplies two single-cycle read strobes and a write strobe, all synchronous to `clk_i`. One read strobe comes from a chip-enable-controlled read and the other from an output-enable-controlled read. Either strobe counts as a sequence step. A recognised command appears as a one-cycle pulse on its own output. A registered state bit, set out of reset, records whether automatic save is enabled. The store and recall operations themselves are carried out by other logic.

Top module: `addr_seq_cmd_det`

## Requirements
- R1: While reset is active and in the first cycle after it, all four command pulses are low and `as_en_o` is high.
- R2: Reads of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F in that order, then a read of 0x8FC0, raise `store_o` for exactly one cycle. That cycle is the one after the clock edge that samples the sixth read.
- R3: The same five-read prefix followed by a read of 0x4C63 raises `recall_o` for one cycle, with the same timing as R2.
- R4: The prefix followed by 0x8B45 raises `as_off_o` for one cycle, and `as_en_o` is low from that same cycle on.
- R5: The prefix followed by 0x4B46 raises `as_on_o` for one cycle, and `as_en_o` is high from that same cycle on.
- R6: At most one command output is high in any cycle, and no command pulse lasts longer than one cycle. `as_en_o` changes only in a cycle where `as_off_o` or `as_on_o` is high.
- R7: A write strobe at any point in the sequence aborts it, and no command follows. A write in the same cycle as a read also aborts, and that read does not count as a step.
- R8: A read of an address that is not the next expected one aborts the sequence, and no command is issued for it.
- R9: A read that aborts the sequence but is of 0x4E38 counts as the first step of a new sequence.
- R10: Either read strobe advances the sequence. When both are high in the same cycle they count as one step.
- R11: After a command the detector is idle again, so a repeated read of the sixth address alone issues nothing.
- R12: Cycles with no strobe do not disturb the progress of a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_rd_i | input | 1 | One-cycle strobe for a chip-enable-controlled read |
| oe_rd_i | input | 1 | One-cycle strobe for an output-enable-controlled read |
| wr_i | input | 1 | One-cycle write strobe |
| addr_i | input | 16 | Address of the current access |
| store_o | output | 1 | Pulse: save RAM to nonvolatile copy |
| recall_o | output | 1 | Pulse: restore RAM from nonvolatile copy |
| as_off_o | output | 1 | Pulse: disable automatic save |
| as_on_o | output | 1 | Pulse: enable automatic save |
| as_en_o | output | 1 | Automatic-save enable state |

## Verification
The properties assume that each bus access produces one strobe cycle, that `addr_i` is valid whenever a strobe is high, and that all strobes are already synchronous to `clk_i`. They also assume a write and a read in the same cycle are legal, with the write taking precedence. The stimulus changes inputs only on the falling clock edge and applies one access per cycle. Most steps of the random traffic follow the correct sequence, with stray addresses, writes, idle cycles and early restarts mixed in, so that commands complete often and partial sequences are aborted at every step.

// File: rtl/seq_cmd_pkg.sv
package seq_cmd_pkg;
  localparam int MATCH_W = 16;
  localparam int PFX_LEN = 5;
  localparam int N_CMD   = 4;
  localparam int STEP_W  = $clog2(PFX_LEN + 1);

  typedef logic [MATCH_W-1:0] addr_t;

  // prefix order is behaviour: step i must match PFX_ADDR[i]
  localparam addr_t PFX_ADDR [PFX_LEN] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};

  localparam int IDX_STORE  = 0;
  localparam int IDX_RECALL = 1;
  localparam int IDX_AS_OFF = 2;
  localparam int IDX_AS_ON  = 3;

  localparam addr_t CMD_ADDR [N_CMD] = '{16'h8FC0, 16'h4C63, 16'h8B45, 16'h4B46};
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import seq_cmd_pkg::*;
(
  input  addr_t             addr_i,
  output logic [N_CMD-1:0]  hit_o
);
  for (genvar c = 0; c < N_CMD; c++) begin : g_cmd
    assign hit_o[c] = (addr_i == CMD_ADDR[c]);
  end
endmodule

// File: rtl/seq_track.sv
module seq_track
  import seq_cmd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_i,
  input  logic  wr_i,
  input  addr_t addr_i,
  input  logic  fire_i,
  output logic  armed_o
);
  logic [STEP_W-1:0] step_q, step_d;
  logic              pfx_hit;

  always_comb begin
    pfx_hit = 1'b0;
    for (int i = 0; i < PFX_LEN; i++) begin
      if (step_q == STEP_W'(i) && addr_i == PFX_ADDR[i]) pfx_hit = 1'b1;
    end
  end

  always_comb begin
    step_d = step_q;
    if (wr_i) begin
      step_d = '0;
    end else if (rd_i) begin
      if (pfx_hit)                    step_d = step_q + STEP_W'(1);
      else if (fire_i)                step_d = '0;
      else if (addr_i == PFX_ADDR[0]) step_d = STEP_W'(1); // restart on abort
      else                            step_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  assign armed_o = (step_q == STEP_W'(PFX_LEN));
endmodule

// File: rtl/addr_seq_cmd_det.sv
module addr_seq_cmd_det
  import seq_cmd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_rd_i,
  input  logic               oe_rd_i,
  input  logic               wr_i,
  input  logic [MATCH_W-1:0] addr_i,
  output logic               store_o,
  output logic               recall_o,
  output logic               as_off_o,
  output logic               as_on_o,
  output logic               as_en_o
);
  logic             rd, armed, fire;
  logic [N_CMD-1:0] hit, pulse_q;
  logic             as_en_q;

  assign rd = ce_rd_i | oe_rd_i;

  cmd_decode u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  assign fire = rd & ~wr_i & armed & (|hit);

  seq_track u_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .fire_i  (fire),
    .armed_o (armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= '0;
      as_en_q <= 1'b1;
    end else begin
      pulse_q <= fire ? hit : '0;
      if (fire && hit[IDX_AS_ON])       as_en_q <= 1'b1;
      else if (fire && hit[IDX_AS_OFF]) as_en_q <= 1'b0;
    end
  end

  assign store_o  = pulse_q[IDX_STORE];
  assign recall_o = pulse_q[IDX_RECALL];
  assign as_off_o = pulse_q[IDX_AS_OFF];
  assign as_on_o  = pulse_q[IDX_AS_ON];
  assign as_en_o  = as_en_q;
endmodule

// File: rtl/addr_seq_cmd_det_chk.sv
module addr_seq_cmd_det_chk
  import seq_cmd_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ce_rd_i,
  input logic               oe_rd_i,
  input logic               wr_i,
  input logic [MATCH_W-1:0] addr_i,
  input logic               store_o,
  input logic               recall_o,
  input logic               as_off_o,
  input logic               as_on_o,
  input logic               as_en_o
);
  logic [3:0] pl;
  assign pl = {as_on_o, as_off_o, recall_o, store_o};

  p_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pl));

  p_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pl) |=> !(|pl));

  p_state_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(as_off_o || as_on_o) |-> $stable(as_en_o));

  p_off_state_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_off_o |-> !as_en_o);

  p_on_state_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_on_o |-> as_en_o);

  p_write_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !(|pl));

  p_store_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> ($past(addr_i) == CMD_ADDR[IDX_STORE] && $past(ce_rd_i || oe_rd_i) && !$past(wr_i)));

  p_recall_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |-> ($past(addr_i) == CMD_ADDR[IDX_RECALL] && $past(ce_rd_i || oe_rd_i)));
endmodule

bind addr_seq_cmd_det addr_seq_cmd_det_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_rd_i  (ce_rd_i),
  .oe_rd_i  (oe_rd_i),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .store_o  (store_o),
  .recall_o (recall_o),
  .as_off_o (as_off_o),
  .as_on_o  (as_on_o),
  .as_en_o  (as_en_o)
);

// File: tb/addr_seq_cmd_det_tb.sv
module addr_seq_cmd_det_tb;
  localparam int CLK_P = 10;

  localparam logic [15:0] P [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
  localparam logic [15:0] C [4] = '{16'h8FC0, 16'h4C63, 16'h8B45, 16'h4B46};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_rd = 1'b0, oe_rd = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic        store, recall, as_off, as_on, as_en;

  int total = 0;
  int bad   = 0;

  int         m_step  = 0;
  logic [3:0] m_pulse = '0;
  logic       m_state = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  addr_seq_cmd_det u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .ce_rd_i  (ce_rd),
    .oe_rd_i  (oe_rd),
    .wr_i     (wr),
    .addr_i   (addr),
    .store_o  (store),
    .recall_o (recall),
    .as_off_o (as_off),
    .as_on_o  (as_on),
    .as_en_o  (as_en)
  );

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic int cmd_of(input logic [15:0] a);
    for (int k = 0; k < 4; k++) if (a == C[k]) return k;
    return -1;
  endfunction

  // reference model, written from the requirements
  task automatic model(input logic ce, input logic oe, input logic w, input logic [15:0] a);
    int k;
    m_pulse = '0;
    if (w) m_step = 0;
    else if (ce || oe) begin
      k = cmd_of(a);
      if (m_step < 5 && a == P[m_step]) m_step++;
      else if (m_step == 5 && k >= 0) begin
        m_pulse[k] = 1'b1;
        if (k == 2) m_state = 1'b0;
        if (k == 3) m_state = 1'b1;
        m_step = 0;
      end else m_step = (a == P[0]) ? 1 : 0;
    end
  endtask

  task automatic cyc(input string tag, input logic ce, input logic oe, input logic w, input logic [15:0] a);
    ce_rd = ce; oe_rd = oe; wr = w; addr = a;
    model(ce, oe, w, a);
    @(negedge clk);
    chk(tag, {as_en, as_on, as_off, recall, store}, {m_state, m_pulse});
  endtask

  task automatic rd(input string tag, input int mode, input logic [15:0] a);
    cyc(tag, mode != 1, mode != 0, 1'b0, a);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 1'b0, 1'b0, 1'b0, $urandom);
  endtask

  task automatic full(input string tag, input int mode, input logic [15:0] last);
    for (int i = 0; i < 5; i++) rd(tag, mode, P[i]);
    rd(tag, mode, last);
    idle(tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 in reset", {as_en, as_on, as_off, recall, store}, 5'b10000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {as_en, as_on, as_off, recall, store}, 5'b10000);

    full("R2 store ce", 0, C[0]);
    full("R3 recall oe R10", 1, C[1]);
    full("R4 disable", 0, C[2]);
    full("R10 both strobes", 2, C[0]);
    full("R5 enable", 1, C[3]);

    for (int i = 0; i < 3; i++) rd("R7 write mid", 0, P[i]);
    cyc("R7 write mid", 0, 0, 1, 16'h0000);
    for (int i = 3; i < 5; i++) rd("R7 write mid", 0, P[i]);
    rd("R7 no cmd", 0, C[0]);

    for (int i = 0; i < 4; i++) rd("R7 write+read", 0, P[i]);
    cyc("R7 write+read", 1, 0, 1, P[4]);
    rd("R7 no cmd", 0, C[1]);

    for (int i = 0; i < 3; i++) rd("R8 bad addr", 1, P[i]);
    rd("R8 bad addr", 1, 16'h1234);
    rd("R8 bad addr", 1, P[3]);
    rd("R8 bad addr", 1, P[4]);
    rd("R8 no cmd", 1, C[0]);

    for (int i = 0; i < 3; i++) rd("R9 restart", 0, P[i]);
    full("R9 restart store", 0, C[0]);

    full("R11 first", 0, C[1]);
    rd("R11 repeat sixth", 0, C[1]);
    rd("R11 repeat sixth", 0, C[2]);

    for (int i = 0; i < 5; i++) begin
      rd("R12 gaps", 2, P[i]);
      idle("R12 gaps");
      idle("R12 gaps");
    end
    rd("R12 gaps cmd", 0, C[2]);
    idle("R12 gaps");

    for (int n = 0; n < 4000; n++) begin
      int r    = $urandom_range(0, 99);
      int mode = $urandom_range(0, 2);
      if (r < 70) begin
        if (m_step < 5) rd("R6 random", mode, P[m_step]);
        else            rd("R6 random", mode, C[$urandom_range(0, 3)]);
      end else if (r < 80) rd("R8 random", mode, 16'($urandom));
      else if (r < 86)     rd("R9 random", mode, P[0]);
      else if (r < 92)     cyc("R7 random", $urandom_range(0, 1) == 1, 1'b0, 1'b1, P[$urandom_range(0, 4)]);
      else                 idle("R12 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule